// File: doc/BRIEF.md
# Latched-Input Parallel/Serial Shift Register

This block holds a byte in two stages. The front stage is a storage latch that takes a snapshot of the parallel data bus whenever the latch strobe rises. The back stage is a shift register. It either copies the front stage or shifts one bit in from a serial input per shift strobe. The last shift stage drives the serial output. A typical use is to capture a set of status lines at one instant, then clock them out bit by bit while the next snapshot is being taken.

Everything runs on one system clock. Both external strobes are synchronised and edge-detected inside the block. Each rising edge becomes a one-cycle enable event. The mode pin, the serial input, the parallel bus and the shift-register clear are sampled directly on the system clock. A system reset clears all state. The separate active-low clear empties only the shift register and leaves the latch as it was.

Top module: `latch_shift_reg`

## Requirements
- R1: A latch-strobe event copies parIn into the latch whatever the level of shiftMode. With shiftMode high, the event leaves the shift register untouched.
- R2: With shiftMode high, a shift-strobe event moves serialIn into stage A (bit 0), moves each stage into the next higher one, and moves stage G into stage H (bit 7).
- R3: While shiftMode is low, the shift register copies the latch on every clock. Shift-strobe events and serialIn have no effect.
- R4: With shiftMode low, a latch-strobe event puts the new parIn into the latch and into the shift register on the same clock edge. That edge is the third rising clock edge after the strobe pin is first seen high.
- R5: srClrN sampled low clears all shift-register stages to zero on the next clock edge, and serialOut goes low. The latch is unchanged.
- R6: While srClrN is low, a latch-strobe event still loads parIn into the latch, and the shift register stays zero.
- R7: With shiftMode high and no strobe event, the latch and the shift register keep their values.
- R8: serialOut always equals stage H (bit 7) of the shift register.
- R9: With shiftMode high, a latch event and a shift event in the same cycle both take effect: the latch takes parIn and the register shifts in serialIn.
- R10: A strobe pin held high for many cycles gives exactly one event per rising edge.
- R11: sysRstN low clears the latch and the shift register to all zeros, so serialOut reads low after reset.
- R12: The clear takes priority over loading and shifting. While srClrN is low, neither load mode nor shift events change the zero contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous active-low system reset for all state |
| srClrN | input | 1 | Synchronous active-low clear of the shift register only |
| shiftMode | input | 1 | High: shift on strobe; low: register follows the latch |
| latchStrobe | input | 1 | Latch strobe pin, rising edge captures parIn |
| shiftStrobe | input | 1 | Shift strobe pin, rising edge shifts in shift mode |
| serialIn | input | 1 | Serial data entering stage A |
| parIn | input | 8 | Parallel data captured by the latch |
| serialOut | output | 1 | Stage H of the shift register |

## Verification
The latch has no port of its own. A corrupted latch therefore shows only after a switch to load mode, when its contents reach the register and, after enough shift events, appear bit by bit on serialOut. The bench reads each register state fully this way, one bit per shift event. A wrong shift-register stage can take up to seven shift events to reach serialOut, so every check shifts all eight bits out. Timing errors in the strobe path show as serialOut changing one edge early or late relative to the third clock edge after a strobe pin rises. The bench samples serialOut on both sides of that edge.

// File: rtl/latch_shift_pkg.sv
package latch_shift_pkg;

  // Per-cycle command from the control module to the datapath.
  typedef struct packed {
    logic latchEv;  // capture parallel bus into the latch
    logic shiftEv;  // shift one position (shift mode only)
    logic loadEn;   // register follows the latch
    logic clearSr;  // zero the shift register
  } lsrCtrl_t;

endpackage

// File: rtl/lsr_edge_sync.sv
module lsr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic sysRstN,
  input  logic pinIn,
  output logic pulseOut
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge sysRstN) begin
          if (!sysRstN) syncQ[gi] <= 1'b0;
          else          syncQ[gi] <= pinIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge sysRstN) begin
          if (!sysRstN) syncQ[gi] <= 1'b0;
          else          syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) prevQ <= 1'b0;
    else          prevQ <= syncQ[LAST];
  end

  assign pulseOut = syncQ[LAST] & ~prevQ;

  // R10: one event per rising edge, never two in a row
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!sysRstN)
    pulseOut |=> !pulseOut);

endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import latch_shift_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     sysRstN,
  input  logic     srClrN,
  input  logic     shiftMode,
  input  logic     latchStrobe,
  input  logic     shiftStrobe,
  output lsrCtrl_t ctl
);

  logic latchPulse;
  logic shiftPulse;

  lsr_edge_sync #(.STAGES(SYNC_STAGES)) u_latchSync (
    .clk(clk), .sysRstN(sysRstN), .pinIn(latchStrobe), .pulseOut(latchPulse)
  );

  lsr_edge_sync #(.STAGES(SYNC_STAGES)) u_shiftSync (
    .clk(clk), .sysRstN(sysRstN), .pinIn(shiftStrobe), .pulseOut(shiftPulse)
  );

  always_comb begin
    ctl.latchEv = latchPulse;
    ctl.loadEn  = ~shiftMode;
    ctl.shiftEv = shiftPulse & shiftMode;
    ctl.clearSr = ~srClrN;
  end

  // R10: a strobe pin held high yields no second event
  assert_no_repeat_latch_R10: assert property (@(posedge clk) disable iff (!sysRstN)
    (latchStrobe && $past(latchStrobe) && $past(latchStrobe, 2) && $past(latchStrobe, 3))
      |-> !latchPulse);

endmodule

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import latch_shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  lsrCtrl_t         ctl,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serialOut
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] latchReg;
  logic [WIDTH-1:0] srReg;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)         latchReg <= '0;
    else if (ctl.latchEv) latchReg <= parIn;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)          srReg <= '0;
    else if (ctl.clearSr)  srReg <= '0;
    else if (ctl.loadEn)   srReg <= ctl.latchEv ? parIn : latchReg;
    else if (ctl.shiftEv)  srReg <= {srReg[TOP-1:0], serialIn};
  end

  assign serialOut = srReg[TOP];

  // R5, R12: clear wins over everything
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!sysRstN)
    ctl.clearSr |=> (srReg == '0));

  // R6: latch still loads while the register is held clear
  assert_latch_under_clear_R6: assert property (@(posedge clk) disable iff (!sysRstN)
    (ctl.clearSr && ctl.latchEv) |=> (latchReg == $past(parIn)));

  // R7: latch holds without an event
  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    !ctl.latchEv |=> $stable(latchReg));

  // R2: one-position shift with serial bit in stage A
  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    (ctl.shiftEv && !ctl.loadEn && !ctl.clearSr)
      |=> (srReg[TOP:1] == $past(srReg[TOP-1:0])) && (srReg[0] == $past(serialIn)));

  // R4: load mode plus latch event puts the same data in both stages
  assert_load_through_R4: assert property (@(posedge clk) disable iff (!sysRstN)
    (ctl.loadEn && ctl.latchEv && !ctl.clearSr) |=> (srReg == latchReg));

  // R3: load mode copies the latch
  assert_follow_latch_R3: assert property (@(posedge clk) disable iff (!sysRstN)
    (ctl.loadEn && !ctl.latchEv && !ctl.clearSr) |=> (srReg == $past(latchReg)));

endmodule

// File: rtl/latch_shift_reg.sv
module latch_shift_reg
  import latch_shift_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  logic             srClrN,
  input  logic             shiftMode,
  input  logic             latchStrobe,
  input  logic             shiftStrobe,
  input  logic             serialIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serialOut
);

  lsrCtrl_t ctl;

  lsr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .sysRstN(sysRstN), .srClrN(srClrN), .shiftMode(shiftMode),
    .latchStrobe(latchStrobe), .shiftStrobe(shiftStrobe), .ctl(ctl)
  );

  lsr_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk(clk), .sysRstN(sysRstN), .ctl(ctl), .serialIn(serialIn),
    .parIn(parIn), .serialOut(serialOut)
  );

endmodule

// File: tb/latch_shift_reg_tb.sv
module latch_shift_reg_tb;

  logic       clk = 1'b0;
  logic       sysRstN = 1'b0;
  logic       srClrN = 1'b1;
  logic       shiftMode = 1'b1;
  logic       latchStrobe = 1'b0;
  logic       shiftStrobe = 1'b0;
  logic       serialIn = 1'b0;
  logic [7:0] parIn = 8'h00;
  logic       serialOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  latch_shift_reg u_dut (
    .clk(clk), .sysRstN(sysRstN), .srClrN(srClrN), .shiftMode(shiftMode),
    .latchStrobe(latchStrobe), .shiftStrobe(shiftStrobe), .serialIn(serialIn),
    .parIn(parIn), .serialOut(serialOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseLatch();
    latchStrobe = 1'b1; waitCycles(4); latchStrobe = 1'b0; waitCycles(4);
  endtask

  task automatic pulseShift();
    shiftStrobe = 1'b1; waitCycles(4); shiftStrobe = 1'b0; waitCycles(4);
  endtask

  // Reads all eight stages through serialOut (shift mode, zeros shifted in).
  task automatic readSr(output logic [7:0] v);
    shiftMode = 1'b1;
    serialIn  = 1'b0;
    v[7] = serialOut;
    for (int i = 6; i >= 0; i--) begin
      pulseShift();
      v[i] = serialOut;
    end
  endtask

  // Copies the latch into the register, then reads it.
  task automatic readLatch(output logic [7:0] v);
    shiftMode = 1'b0; waitCycles(2);
    shiftMode = 1'b1; waitCycles(1);
    readSr(v);
  endtask

  task automatic testReset();
    logic [7:0] v;
    waitCycles(3); sysRstN = 1'b1; waitCycles(2);
    check("R11 serialOut after reset", {7'b0, serialOut}, 8'h00);
    readSr(v);     check("R11 register after reset", v, 8'h00);
    readLatch(v);  check("R11 latch after reset", v, 8'h00);
  endtask

  task automatic testLatchShiftMode();
    logic [7:0] v;
    shiftMode = 1'b1; parIn = 8'hA5; pulseLatch();
    check("R1 register untouched by latch event", {7'b0, serialOut}, 8'h00);
    readSr(v);    check("R1 register still zero", v, 8'h00);
    readLatch(v); check("R1 latch captured in shift mode", v, 8'hA5);
  endtask

  task automatic testShift();
    logic [7:0] v;
    logic [7:0] exp;
    logic [7:0] pat;
    pat = 8'b1011_0010;
    exp = 8'h00;
    srClrN = 1'b0; waitCycles(1); srClrN = 1'b1; waitCycles(1);
    shiftMode = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      serialIn = pat[i];
      pulseShift();
      exp = {exp[6:0], pat[i]};
      check("R8 serialOut is stage H", {7'b0, serialOut}, {7'b0, exp[7]});
    end
    waitCycles(10);
    readSr(v); check("R2 R7 shifted pattern held", v, pat);
  endtask

  task automatic testLoadIgnoresShift();
    logic [7:0] v;
    parIn = 8'h3C; pulseLatch();
    shiftMode = 1'b0; waitCycles(2);
    serialIn = 1'b1; pulseShift(); pulseShift();
    check("R3 serialOut follows latch", {7'b0, serialOut}, 8'h00);
    readSr(v); check("R3 shift events ignored in load mode", v, 8'h3C);
  endtask

  task automatic testLoadThrough();
    logic [7:0] v;
    shiftMode = 1'b0; waitCycles(2);
    parIn = 8'h96;
    latchStrobe = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R4 not yet loaded after two edges", {7'b0, serialOut}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R4 loaded on third edge", {7'b0, serialOut}, 8'h01);
    latchStrobe = 1'b0; waitCycles(4);
    readSr(v); check("R4 register got new data", v, 8'h96);
  endtask

  task automatic testBoth();
    logic [7:0] v;
    shiftMode = 1'b0; waitCycles(2); shiftMode = 1'b1; waitCycles(1);
    parIn = 8'h0F; serialIn = 1'b1;
    latchStrobe = 1'b1; shiftStrobe = 1'b1; waitCycles(4);
    latchStrobe = 1'b0; shiftStrobe = 1'b0; waitCycles(4);
    readSr(v);    check("R9 shift in same cycle as latch", v, 8'h2D);
    readLatch(v); check("R9 latch in same cycle as shift", v, 8'h0F);
  endtask

  task automatic testHeldStrobe();
    logic [7:0] v;
    shiftMode = 1'b0; waitCycles(2); shiftMode = 1'b1; waitCycles(1);
    serialIn = 1'b0;
    shiftStrobe = 1'b1; waitCycles(12); shiftStrobe = 1'b0; waitCycles(4);
    readSr(v); check("R10 one shift for long strobe", v, 8'h1E);
  endtask

  task automatic testClear();
    logic [7:0] v;
    shiftMode = 1'b0; parIn = 8'hF0; pulseLatch();
    check("R4 register shows F0", {7'b0, serialOut}, 8'h01);
    srClrN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R5 clear zeroes stage H next edge", {7'b0, serialOut}, 8'h00);
    parIn = 8'h81; pulseLatch();
    check("R6 R12 register stays zero in load mode", {7'b0, serialOut}, 8'h00);
    shiftMode = 1'b1; serialIn = 1'b1; pulseShift(); pulseShift();
    srClrN = 1'b1; waitCycles(1);
    readSr(v);    check("R12 shifts ignored under clear", v, 8'h00);
    readLatch(v); check("R6 latch loaded during clear", v, 8'h81);
    srClrN = 1'b0; waitCycles(2); srClrN = 1'b1;
    readLatch(v); check("R5 clear keeps latch", v, 8'h81);
  endtask

  task automatic testSysReset();
    logic [7:0] v;
    sysRstN = 1'b0; waitCycles(2); sysRstN = 1'b1; waitCycles(2);
    readLatch(v); check("R11 latch cleared by system reset", v, 8'h00);
  endtask

  initial begin
    testReset();
    testLatchShiftMode();
    testShift();
    testLoadIgnoresShift();
    testLoadThrough();
    testBoth();
    testHeldStrobe();
    testClear();
    testSysReset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule